// File: doc/BRIEF.md
# DMA Physical Address and Count Generator

This block keeps the address state of one DMA channel. From it the block forms the 24-bit physical memory address and the byte-lane enables for every transfer. A start address and a byte length are loaded together. The top byte of the address becomes the page, which stays fixed for the whole transfer. The low part goes into a 16-bit current-address counter. Each transfer strobe moves the counter forward by one unit and takes one unit off the transfer count.

There are two channel kinds, and the `word_mode` input chooses between them at load time.
- **Byte channel:** moves bytes and uses 64K-byte pages.
- **Word channel:** moves aligned 16-bit words and uses 128K-byte pages. The counter is shifted up one bit, and page bit 0 is not used.

The counter never carries into the page. When it wraps while transfers are still left, the transfer would have crossed its page boundary, and the block raises a sticky error flag.

The block also does two conversions. It turns a requested byte length into the count value that is programmed, which is the number of units minus one. It turns the live count back into the number of bytes still to move.

The control is a four-state machine:
- **IDLE:** the state after reset.
- **RUN:** transferring.
- **WRAPPED:** still transferring after the counter crossed the page boundary.
- **DONE:** the last unit has been moved.

The transitions are:
- IDLE→RUN, RUN→RUN, WRAPPED→RUN and DONE→RUN on a load.
- RUN→DONE and WRAPPED→DONE on the strobe of the last unit.
- RUN→WRAPPED on a strobe that wraps the counter while units remain.

Top module: `dma_addr_gen`

## Requirements
- R1: After reset the block is idle: `busy`, `done` and `bound_err` are 0, `byte_en` is 00, `phys_addr` is 0 and `remain_bytes` is 0.
- R2: On a byte channel `phys_addr` = {page, counter}. While busy, `byte_en` is 01 when `phys_addr[0]` is 0 and 10 when it is 1. At load the counter takes address bits 15:0.
- R3: On a word channel `phys_addr` = {page[7:1], counter, 0}, and `byte_en` is 11 while busy. At load the counter takes address bits 16:1, so address bit 0 has no effect.
- R4: A strobe while busy adds one to the counter, which is one byte or one word. A strobe while idle or done changes neither the address nor the remaining bytes.
- R5: `prog_count` is a 16-bit combinational value. It is `load_len`−1 on a byte channel and (`load_len`>>1)−1 on a word channel. A length of 65536 bytes (byte channel) or 131072 bytes (word channel) gives 0xFFFF.
- R6: `remain_bytes` is the live count plus one, wrapped to 16 bits. It is doubled on a word channel. A finished transfer reads 0, and a full 65536-unit count also reads 0 before its first strobe.
- R7: The strobe for the last unit (count 0) moves the machine to DONE. Then `done` is 1, `busy` is 0 and `byte_en` is 00.
- R8: The counter wraps from 0xFFFF to 0 inside the page. Between loads the page never changes.
- R9: `bound_err` goes to 1 when the counter wraps on a strobe that is not the last one. It stays 1 until the next load. A wrap on the final strobe does not raise it.
- R10: A load is accepted in any state and has priority over a strobe in the same cycle. It restarts in RUN, clears `bound_err`, and latches `word_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_mode | input | 1 | 1 selects a word channel, 0 a byte channel; latched on load |
| load | input | 1 | Load start address and length, start a transfer |
| load_addr | input | 24 | Start byte address |
| load_len | input | 18 | Requested length in bytes |
| step | input | 1 | Transfer strobe: one unit moved |
| phys_addr | output | 24 | Physical address of the current unit |
| byte_en | output | 2 | Byte-lane enables, bit 0 = even lane |
| prog_count | output | 16 | Count value to program for `load_len` |
| remain_bytes | output | 18 | Bytes still to move |
| busy | output | 1 | In RUN or WRAPPED |
| done | output | 1 | In DONE |
| bound_err | output | 1 | Sticky page-crossing error |

## Verification
`prog_count` is purely combinational. It is checked 1 ns after its inputs are driven, with no clock edge in between. Everything else is registered. It follows a load or a strobe with exactly one clock edge of delay, so stimulus is applied at the falling edge and results are sampled at the next falling edge. That point is after the single rising edge that updates them and before any later stimulus. The boundary cases are:
- a counter wrap on the final unit, on both channel kinds;
- a wrap with units still left;
- strobes in IDLE and in DONE;
- the maximum lengths;
- an odd start address on a word channel.

// File: rtl/dma_ag_pkg.sv
package dma_ag_pkg;
    typedef enum logic [1:0] {
        AG_IDLE    = 2'd0,
        AG_RUN     = 2'd1,
        AG_WRAPPED = 2'd2,
        AG_DONE    = 2'd3
    } ag_state_t;
endpackage

// File: rtl/dma_len_conv.sv
module dma_len_conv #(
    parameter int CTR_W = 16,
    parameter int LEN_W = CTR_W + 2
) (
    input  logic             req_word,
    input  logic [LEN_W-1:0] req_len,
    input  logic             live_word,
    input  logic [CTR_W-1:0] live_cnt,
    output logic [CTR_W-1:0] prog,
    output logic [LEN_W-1:0] remain
);
    logic [LEN_W-1:0] units;
    logic [LEN_W-1:0] units_m1;
    logic [CTR_W-1:0] left_units;

    always_comb begin
        units    = req_word ? (req_len >> 1) : req_len;
        units_m1 = units - LEN_W'(1);
        prog     = units_m1[CTR_W-1:0];
    end

    always_comb begin
        left_units = live_cnt + CTR_W'(1);
        if (live_word)
            remain = {1'b0, left_units, 1'b0};
        else
            remain = {2'b00, left_units};
    end
endmodule

// File: rtl/dma_ag_fsm.sv
module dma_ag_fsm
    import dma_ag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic step,
    input  logic last_unit,
    input  logic ctr_full,
    output logic active,
    output logic finished,
    output logic err,
    output logic adv
);
    ag_state_t state_q, state_d;
    logic      err_q, err_d;

    always_comb begin
        state_d = state_q;
        err_d   = err_q;
        unique case (state_q)
            AG_IDLE: begin
                if (load) state_d = AG_RUN;
            end
            AG_RUN: begin
                if (load)
                    state_d = AG_RUN;
                else if (step && last_unit)
                    state_d = AG_DONE;
                else if (step && ctr_full) begin
                    state_d = AG_WRAPPED;
                    err_d   = 1'b1;
                end
            end
            AG_WRAPPED: begin
                if (load)
                    state_d = AG_RUN;
                else if (step && last_unit)
                    state_d = AG_DONE;
            end
            AG_DONE: begin
                if (load) state_d = AG_RUN;
            end
            default: state_d = AG_IDLE;
        endcase
        if (load) err_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= AG_IDLE;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= err_d;
        end
    end

    always_comb begin
        active   = 1'b0;
        finished = 1'b0;
        unique case (state_q)
            AG_IDLE:    ;
            AG_RUN:     active = 1'b1;
            AG_WRAPPED: active = 1'b1;
            AG_DONE:    finished = 1'b1;
            default:    ;
        endcase
        err = err_q;
        adv = active && step && !load;
    end

    // R9
    wrap_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && step && !load && ctr_full && !last_unit) |=> err);
    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !load) |=> err);
    // R7
    last_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && step && !load && last_unit) |=> (finished && !active));
    // R10
    load_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (active && !err));
endmodule

// File: rtl/dma_ag_dp.sv
module dma_ag_dp #(
    parameter int PAGE_W = 8,
    parameter int CTR_W  = 16,
    localparam int ADDR_W = PAGE_W + CTR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              adv,
    input  logic              word_in,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CTR_W-1:0]  start_cnt,
    output logic [PAGE_W-1:0] page,
    output logic [CTR_W-1:0]  ctr,
    output logic [CTR_W-1:0]  cnt,
    output logic              word_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page   <= '0;
            ctr    <= '0;
            cnt    <= '1;
            word_q <= 1'b0;
        end else if (load) begin
            page   <= start_addr[ADDR_W-1:CTR_W];
            ctr    <= word_in ? start_addr[CTR_W:1] : start_addr[CTR_W-1:0];
            cnt    <= start_cnt;
            word_q <= word_in;
        end else if (adv) begin
            ctr <= ctr + CTR_W'(1);
            cnt <= cnt - CTR_W'(1);
        end
    end

    // R8
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(page));
    // R4
    ctr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv) |=> ($stable(ctr) && $stable(cnt)));
    // R4
    ctr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && adv) |=> (ctr == $past(ctr) + CTR_W'(1)));
endmodule

// File: rtl/dma_addr_map.sv
module dma_addr_map #(
    parameter int PAGE_W = 8,
    parameter int CTR_W  = 16,
    localparam int ADDR_W = PAGE_W + CTR_W
) (
    input  logic              word_sel,
    input  logic              active,
    input  logic [PAGE_W-1:0] page,
    input  logic [CTR_W-1:0]  ctr,
    output logic [ADDR_W-1:0] addr,
    output logic [1:0]        lanes
);
    always_comb begin
        if (word_sel)
            addr = {page[PAGE_W-1:1], ctr, 1'b0};
        else
            addr = {page, ctr};
        if (!active)
            lanes = 2'b00;
        else if (word_sel)
            lanes = 2'b11;
        else
            lanes = addr[0] ? 2'b10 : 2'b01;
    end
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
    parameter int PAGE_W = 8,
    parameter int CTR_W  = 16,
    localparam int ADDR_W = PAGE_W + CTR_W,
    localparam int LEN_W  = CTR_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_mode,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [LEN_W-1:0]  load_len,
    input  logic              step,
    output logic [ADDR_W-1:0] phys_addr,
    output logic [1:0]        byte_en,
    output logic [CTR_W-1:0]  prog_count,
    output logic [LEN_W-1:0]  remain_bytes,
    output logic              busy,
    output logic              done,
    output logic              bound_err
);
    logic [PAGE_W-1:0] page;
    logic [CTR_W-1:0]  ctr;
    logic [CTR_W-1:0]  cnt;
    logic              word_q;
    logic              adv;
    logic              last_unit;
    logic              ctr_full;

    assign last_unit = (cnt == '0);
    assign ctr_full  = (ctr == '1);

    dma_len_conv #(.CTR_W(CTR_W), .LEN_W(LEN_W)) u_conv (
        .req_word (word_mode),
        .req_len  (load_len),
        .live_word(word_q),
        .live_cnt (cnt),
        .prog     (prog_count),
        .remain   (remain_bytes)
    );

    dma_ag_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .last_unit(last_unit),
        .ctr_full (ctr_full),
        .active   (busy),
        .finished (done),
        .err      (bound_err),
        .adv      (adv)
    );

    dma_ag_dp #(.PAGE_W(PAGE_W), .CTR_W(CTR_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .adv       (adv),
        .word_in   (word_mode),
        .start_addr(load_addr),
        .start_cnt (prog_count),
        .page      (page),
        .ctr       (ctr),
        .cnt       (cnt),
        .word_q    (word_q)
    );

    dma_addr_map #(.PAGE_W(PAGE_W), .CTR_W(CTR_W)) u_map (
        .word_sel(word_q),
        .active  (busy),
        .page    (page),
        .ctr     (ctr),
        .addr    (phys_addr),
        .lanes   (byte_en)
    );

    // R2
    byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !word_q) |-> ($onehot(byte_en) && (byte_en[1] == phys_addr[0])));
    // R3
    word_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && word_q) |-> (byte_en == 2'b11 && !phys_addr[0]));
    // R7
    idle_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (byte_en == 2'b00));
endmodule

// File: tb/dma_addr_gen_tb.sv
module dma_addr_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_mode = 1'b0;
    logic        load = 1'b0;
    logic [23:0] load_addr = '0;
    logic [17:0] load_len = '0;
    logic        step = 1'b0;
    logic [23:0] phys_addr;
    logic [1:0]  byte_en;
    logic [15:0] prog_count;
    logic [17:0] remain_bytes;
    logic        busy, done, bound_err;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dma_addr_gen dut_i (
        .clk(clk), .rst_n(rst_n), .word_mode(word_mode), .load(load),
        .load_addr(load_addr), .load_len(load_len), .step(step),
        .phys_addr(phys_addr), .byte_en(byte_en), .prog_count(prog_count),
        .remain_bytes(remain_bytes), .busy(busy), .done(done),
        .bound_err(bound_err)
    );

    task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
        end
    endtask

    task automatic do_load(logic wm, logic [23:0] a, logic [17:0] len);
        @(negedge clk);
        word_mode = wm; load_addr = a; load_len = len; load = 1'b1; step = 1'b0;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic do_steps(int n);
        for (int i = 0; i < n; i++) begin
            step = 1'b1;
            @(negedge clk);
        end
        step = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);
        chk("R1", "bound_err", bound_err, 0);
        chk("R1", "byte_en", byte_en, 0);
        chk("R1", "phys_addr", phys_addr, 0);
        chk("R1", "remain", remain_bytes, 0);
    endtask

    task automatic t_prog;
        @(negedge clk);
        word_mode = 0; load_len = 18'd65536; #1;
        chk("R5", "byte max", prog_count, 16'hFFFF);
        word_mode = 1; load_len = 18'd131072; #1;
        chk("R5", "word max", prog_count, 16'hFFFF);
        word_mode = 0; load_len = 18'd1; #1;
        chk("R5", "byte 1", prog_count, 16'h0000);
        word_mode = 1; load_len = 18'd2; #1;
        chk("R5", "word 2", prog_count, 16'h0000);
        word_mode = 1; load_len = 18'd100; #1;
        chk("R5", "word 100", prog_count, 16'd49);
    endtask

    task automatic t_byte_run;
        do_load(0, 24'h123456, 18'd4);
        chk("R2", "addr", phys_addr, 24'h123456);
        chk("R2", "lane even", byte_en, 2'b01);
        chk("R6", "remain", remain_bytes, 4);
        chk("R10", "busy", busy, 1);
        do_steps(1);
        chk("R4", "addr+1", phys_addr, 24'h123457);
        chk("R2", "lane odd", byte_en, 2'b10);
        chk("R6", "remain 3", remain_bytes, 3);
        do_steps(3);
        chk("R7", "done", done, 1);
        chk("R7", "busy", busy, 0);
        chk("R7", "lanes", byte_en, 2'b00);
        chk("R6", "finished remain", remain_bytes, 0);
        do_steps(2);
        chk("R4", "ignored in done addr", phys_addr, 24'h12345A);
        chk("R4", "ignored in done remain", remain_bytes, 0);
        chk("R9", "no err", bound_err, 0);
    endtask

    task automatic t_word_run;
        do_load(1, 24'h352469, 18'd6);
        chk("R3", "addr odd ignored", phys_addr, 24'h352468);
        chk("R3", "lanes", byte_en, 2'b11);
        chk("R6", "word remain", remain_bytes, 6);
        do_steps(1);
        chk("R4", "word addr+2", phys_addr, 24'h35246A);
        chk("R6", "word remain 4", remain_bytes, 4);
    endtask

    task automatic t_byte_wrap;
        do_load(0, 24'h07FFFE, 18'd2);
        do_steps(2);
        chk("R9", "final wrap no err", bound_err, 0);
        chk("R8", "wrap in page", phys_addr, 24'h070000);
        chk("R7", "done", done, 1);
        do_load(0, 24'h07FFFE, 18'd4);
        do_steps(2);
        chk("R9", "err raised", bound_err, 1);
        chk("R8", "page kept", phys_addr, 24'h070000);
        chk("R8", "still busy", busy, 1);
        do_steps(2);
        chk("R9", "err sticky", bound_err, 1);
        chk("R7", "done after wrap", done, 1);
        do_load(0, 24'h000010, 18'd1);
        chk("R10", "err cleared", bound_err, 0);
    endtask

    task automatic t_word_wrap;
        do_load(1, 24'h09FFFC, 18'd6);
        chk("R3", "start", phys_addr, 24'h09FFFC);
        do_steps(2);
        chk("R8", "128K wrap", phys_addr, 24'h080000);
        chk("R9", "word err", bound_err, 1);
    endtask

    task automatic t_reload_prio;
        @(negedge clk);
        word_mode = 0; load_addr = 24'hABCD01; load_len = 18'd65536;
        load = 1'b1; step = 1'b1;
        @(negedge clk);
        load = 1'b0; step = 1'b0;
        chk("R10", "load over step", phys_addr, 24'hABCD01);
        chk("R10", "mode latched byte", byte_en, 2'b10);
        chk("R6", "full count reads 0", remain_bytes, 0);
        @(negedge clk);
        word_mode = 1;
        @(negedge clk);
        chk("R10", "mode held", byte_en, 2'b10);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        step = 1'b1;
        @(negedge clk);
        step = 1'b0;
        chk("R4", "step in idle", phys_addr, 0);
        chk("R4", "idle busy", busy, 0);
        t_prog;
        t_byte_run;
        t_word_run;
        t_byte_wrap;
        t_word_wrap;
        t_reload_prio;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule